// File: doc/BRIEF.md
# Device Select Strobe Decoder

This block sits between a small sequencing controller and up to fifteen peripheral ports that share one 8-bit data bus. Each cycle the controller presents a 4-bit port code, a read/write qualifier and a strobe-valid phase. The block turns these into two one-hot families of enables, one for reads and one for writes. The read family also sets the direction of the shared bus transceiver. During a read the selected port's data goes onto the bus. At all other times the transceiver faces the peripherals and the read side of the bus floats at high impedance.

A small bank of control registers is mapped onto the lowest write ports. Each register takes bus data on its write strobe and then holds it as a static set of control lines for downstream circuits until the next write to the same port. Code zero is reserved as an idle code and selects nothing.

Top module: `iosel_hub`

## Requirements
- R1: With sel_code equal to 0, every bit of rd_en and wr_en is 0, whatever sel_valid and rd_wr are.
- R2: With sel_valid high, rd_wr high (1 = read) and sel_code = k (1..15), rd_en has only bit k-1 set and wr_en is all zeros.
- R3: With sel_valid high, rd_wr low (0 = write) and sel_code = k (1..15), wr_en has only bit k-1 set and rd_en is all zeros.
- R4: While sel_valid is low, rd_en and wr_en are all zeros.
- R5: At most one bit across rd_en and wr_en together is set in any cycle.
- R6: xcvr_dir is 1 (driver mode, data toward the controller) exactly when a read strobe is active. Otherwise it is 0 (receiver mode).
- R7: While the read strobe for port k is active, bus_rdata equals port_rdata bits [8*(k-1)+7 : 8*(k-1)]. With no read strobe, bus_rdata is high impedance.
- R8: Control register i (0..2) is mapped to write port i+1 and appears on ctrl_q bits [8*i+7 : 8*i]. On the clock edge where that port's write strobe is active, it loads bus_wdata.
- R9: After reset, every control register reads all zeros.
- R10: A control register keeps its value across cycles with no write strobe to its own port, including writes and reads to other ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_code | input | 4 | Port code from the controller; 0 means idle |
| rd_wr | input | 1 | 1 = read cycle, 0 = write cycle |
| sel_valid | input | 1 | Strobe phase; strobes are only issued while high |
| bus_wdata | input | 8 | Data the controller places on the bus for writes |
| port_rdata | input | 120 | Read data of the 15 ports, port k in byte k-1 |
| rd_en | output | 15 | One-hot read strobes, bit k-1 for port k |
| wr_en | output | 15 | One-hot write strobes, bit k-1 for port k |
| xcvr_dir | output | 1 | Bus transceiver direction, 1 = driver mode |
| bus_rdata | output | 8 | Selected read data, high impedance when idle |
| ctrl_q | output | 24 | Held outputs of the three control registers |

## Verification
Control register hold behaviour is the hard part to reach. A register must be shown to keep its value while strobes for neighbouring ports, reads of its own port and idle codes pass by. Before each such pass, the stimulus loads distinctive non-zero patterns into all three registers. It then interleaves writes to non-register ports, reads and code-zero cycles. Every cycle compares the whole register bank against a model. Back-to-back writes to the same port then confirm that each edge captures only the current word.

// File: rtl/iosel_pkg.sv
package iosel_pkg;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned NUM_CTRL = 3;
  localparam int unsigned CTRL_BASE = 1;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } xcvr_dir_e;
endpackage

// File: rtl/iosel_decode.sv
module iosel_decode #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned NPORT  = (1 << CODE_W) - 1
) (
  input  logic [CODE_W-1:0] sel_code,
  input  logic              sel_valid,
  input  logic              rd_wr,
  output logic [NPORT-1:0]  rd_en,
  output logic [NPORT-1:0]  wr_en
);
  logic [NPORT-1:0] hit;

  // code k+1 selects port index k; code 0 has no slot
  for (genvar k = 0; k < NPORT; k++) begin : g_port
    localparam logic [CODE_W-1:0] PortCode = CODE_W'(k + 1);
    assign hit[k]   = sel_valid && (sel_code == PortCode);
    assign rd_en[k] = hit[k] && rd_wr;
    assign wr_en[k] = hit[k] && !rd_wr;
  end
endmodule

// File: rtl/iosel_rdmux.sv
module iosel_rdmux
  import iosel_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NPORT  = 15
) (
  input  logic [NPORT-1:0]        rd_en,
  input  logic [NPORT*DATA_W-1:0] port_rdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    xcvr_dir
);
  logic [DATA_W-1:0] sel_data;
  logic              any_rd;

  // AND-OR mux: strobes are one-hot, so no priority chain is needed
  always_comb begin
    sel_data = '0;
    for (int k = 0; k < NPORT; k++) begin
      if (rd_en[k]) sel_data = sel_data | port_rdata[k*DATA_W +: DATA_W];
    end
  end

  assign any_rd    = |rd_en;
  assign xcvr_dir  = any_rd ? DIR_TX : DIR_RX;
  assign bus_rdata = any_rd ? sel_data : {DATA_W{1'bz}};
endmodule

// File: rtl/iosel_ctlbank.sv
module iosel_ctlbank #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_CTRL = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CTRL-1:0]        ld_en,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [NUM_CTRL*DATA_W-1:0] ctrl_q
);
  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
    logic [DATA_W-1:0] q_r;
    logic [DATA_W-1:0] q_nxt;

    always_comb begin
      q_nxt = q_r;
      if (ld_en[i]) q_nxt = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= q_nxt;
    end

    assign ctrl_q[i*DATA_W +: DATA_W] = q_r;
  end
endmodule

// File: rtl/iosel_hub.sv
module iosel_hub
  import iosel_pkg::*;
#(
  parameter int unsigned P_CODE_W    = CODE_W,
  parameter int unsigned P_DATA_W    = DATA_W,
  parameter int unsigned P_NUM_CTRL  = NUM_CTRL,
  parameter int unsigned P_CTRL_BASE = CTRL_BASE,
  localparam int unsigned NPORT      = (1 << P_CODE_W) - 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [P_CODE_W-1:0]          sel_code,
  input  logic                         rd_wr,
  input  logic                         sel_valid,
  input  logic [P_DATA_W-1:0]          bus_wdata,
  input  logic [NPORT*P_DATA_W-1:0]    port_rdata,
  output logic [NPORT-1:0]             rd_en,
  output logic [NPORT-1:0]             wr_en,
  output logic                         xcvr_dir,
  output logic [P_DATA_W-1:0]          bus_rdata,
  output logic [P_NUM_CTRL*P_DATA_W-1:0] ctrl_q
);
  logic [1:0] rst_sync_r;
  logic       rst_core_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_r <= 2'b00;
    else        rst_sync_r <= {rst_sync_r[0], 1'b1};
  end
  assign rst_core_n = rst_sync_r[1];

  iosel_decode #(.CODE_W(P_CODE_W), .NPORT(NPORT)) u_decode (
    .sel_code  (sel_code),
    .sel_valid (sel_valid),
    .rd_wr     (rd_wr),
    .rd_en     (rd_en),
    .wr_en     (wr_en)
  );

  iosel_rdmux #(.DATA_W(P_DATA_W), .NPORT(NPORT)) u_rdmux (
    .rd_en      (rd_en),
    .port_rdata (port_rdata),
    .bus_rdata  (bus_rdata),
    .xcvr_dir   (xcvr_dir)
  );

  iosel_ctlbank #(.DATA_W(P_DATA_W), .NUM_CTRL(P_NUM_CTRL)) u_ctlbank (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ld_en     (wr_en[P_CTRL_BASE-1 +: P_NUM_CTRL]),
    .bus_wdata (bus_wdata),
    .ctrl_q    (ctrl_q)
  );
endmodule

// File: rtl/iosel_hub_chk.sv
module iosel_hub_chk #(
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_CTRL  = 3,
  parameter int unsigned CTRL_BASE = 1,
  parameter int unsigned NPORT     = 15
) (
  input logic                       clk,
  input logic                       rst_core_n,
  input logic [CODE_W-1:0]          sel_code,
  input logic                       sel_valid,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic [NPORT-1:0]           rd_en,
  input logic [NPORT-1:0]           wr_en,
  input logic                       xcvr_dir,
  input logic [NUM_CTRL*DATA_W-1:0] ctrl_q
);
  // R1
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sel_code == '0) |-> (rd_en == '0 && wr_en == '0));

  // R4
  no_valid_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !sel_valid |-> (rd_en == '0 && wr_en == '0));

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0({rd_en, wr_en}));

  // R6
  dir_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    xcvr_dir == (rd_en != '0));

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg_chk
    // R8
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
      wr_en[CTRL_BASE-1+i] |=> (ctrl_q[i*DATA_W +: DATA_W] == $past(bus_wdata)));
    // R10
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
      !wr_en[CTRL_BASE-1+i] |=> $stable(ctrl_q[i*DATA_W +: DATA_W]));
  end
endmodule

bind iosel_hub iosel_hub_chk #(
  .CODE_W(P_CODE_W), .DATA_W(P_DATA_W), .NUM_CTRL(P_NUM_CTRL),
  .CTRL_BASE(P_CTRL_BASE), .NPORT(NPORT)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .sel_code   (sel_code),
  .sel_valid  (sel_valid),
  .bus_wdata  (bus_wdata),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .xcvr_dir   (xcvr_dir),
  .ctrl_q     (ctrl_q)
);

// File: tb/iosel_hub_bench.sv
module iosel_hub_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 15;

  typedef struct {
    string       req;
    logic [14:0] rd;
    logic [14:0] wr;
    logic        dir;
    logic        chk_data;
    logic [7:0]  data;
    logic [23:0] ctrl;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   sel_code;
  logic         rd_wr;
  logic         sel_valid;
  logic [7:0]   bus_wdata;
  logic [119:0] port_rdata;
  logic [14:0]  rd_en;
  logic [14:0]  wr_en;
  logic         xcvr_dir;
  wire  [7:0]   bus_rdata;
  logic [23:0]  ctrl_q;

  int checks = 0;
  int failures = 0;
  item_t sb_q[$];
  logic [23:0] exp_ctrl;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iosel_hub u_iosel_hub (
    .clk(clk), .rst_n(rst_n), .sel_code(sel_code), .rd_wr(rd_wr),
    .sel_valid(sel_valid), .bus_wdata(bus_wdata), .port_rdata(port_rdata),
    .rd_en(rd_en), .wr_en(wr_en), .xcvr_dir(xcvr_dir),
    .bus_rdata(bus_rdata), .ctrl_q(ctrl_q)
  );

  function automatic logic [7:0] pat(int k);
    return 8'(k * 16) ^ 8'h5A;
  endfunction

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(input string req, input logic [3:0] code,
                       input logic rw, input logic v, input logic [7:0] wd);
    item_t it;
    @(negedge clk);
    sel_code = code; rd_wr = rw; sel_valid = v; bus_wdata = wd;
    it.req = req; it.rd = '0; it.wr = '0; it.dir = 1'b0;
    it.chk_data = 1'b0; it.data = '0;
    if (v && code != 0) begin
      if (rw) begin
        it.rd[code-1] = 1'b1; it.dir = 1'b1;
        it.chk_data = 1'b1; it.data = pat(int'(code));
      end else begin
        it.wr[code-1] = 1'b1;
        if (code >= 1 && code <= 3) exp_ctrl[(code-1)*8 +: 8] = wd;
      end
    end
    it.ctrl = exp_ctrl;
    sb_q.push_back(it);
  endtask

  // monitor: samples a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (sb_q.size() > 0) begin
      item_t e;
      e = sb_q.pop_front();
      checks++;
      if (rd_en !== e.rd || wr_en !== e.wr || xcvr_dir !== e.dir ||
          ctrl_q !== e.ctrl || (e.chk_data && bus_rdata !== e.data)) begin
        failures++;
        $display("FAIL %s: rd=%h wr=%h dir=%b data=%h ctrl=%h expected rd=%h wr=%h dir=%b data=%h ctrl=%h",
                 e.req, rd_en, wr_en, xcvr_dir, bus_rdata, ctrl_q,
                 e.rd, e.wr, e.dir, e.data, e.ctrl);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 1; k <= NP; k++) port_rdata[(k-1)*8 +: 8] = pat(k);
    rst_n = 1'b0; sel_code = '0; rd_wr = 1'b0; sel_valid = 1'b0;
    bus_wdata = '0; exp_ctrl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;   // R9 reset state
    if (ctrl_q !== 24'h0 || rd_en !== '0 || wr_en !== '0 || xcvr_dir !== 1'b0) begin
      failures++;
      $display("FAIL R9: ctrl=%h rd=%h wr=%h expected ctrl=0 rd=0 wr=0", ctrl_q, rd_en, wr_en);
    end

    // R3 R8: load every control register
    drive("R3_R8", 4'd1, 1'b0, 1'b1, 8'hA1);
    drive("R3_R8", 4'd2, 1'b0, 1'b1, 8'hB2);
    drive("R3_R8", 4'd3, 1'b0, 1'b1, 8'hC3);
    // R2 R6 R7: read every port
    for (int k = 1; k <= NP; k++) drive("R2_R6_R7", 4'(k), 1'b1, 1'b1, 8'hFF);
    // R1: idle code both directions
    drive("R1", 4'd0, 1'b1, 1'b1, 8'h11);
    drive("R1", 4'd0, 1'b0, 1'b1, 8'h22);
    // R4: valid low, write to a register port must not load
    drive("R4", 4'd2, 1'b0, 1'b0, 8'h33);
    drive("R4", 4'd5, 1'b1, 1'b0, 8'h44);
    // R10: writes to non-register ports and reads of register ports
    for (int k = 4; k <= NP; k++) drive("R10_R3_R5", 4'(k), 1'b0, 1'b1, 8'(k));
    drive("R10", 4'd1, 1'b1, 1'b1, 8'h66);
    drive("R10", 4'd3, 1'b1, 1'b1, 8'h77);
    // R8: back-to-back writes to one port
    drive("R8", 4'd2, 1'b0, 1'b1, 8'h01);
    drive("R8", 4'd2, 1'b0, 1'b1, 8'hFE);
    drive("R8", 4'd3, 1'b0, 1'b1, 8'h00);
    drive("R10", 4'd0, 1'b0, 1'b0, 8'h99);
    drive("R10", 4'd9, 1'b0, 1'b1, 8'h5C);
    // R5 R6: alternate read/write quickly
    drive("R5_R6", 4'd15, 1'b1, 1'b1, 8'h00);
    drive("R5_R6", 4'd15, 1'b0, 1'b1, 8'h10);
    drive("R5_R6", 4'd1, 1'b0, 1'b1, 8'h3C);
    drive("R5_R6", 4'd1, 1'b1, 1'b1, 8'h00);
    drive("R4_R6", 4'd1, 1'b1, 1'b0, 8'h00);
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule